// File: doc/BRIEF.md
# Privileged Interrupt Selector

This block decides, once per clock, whether a hart that runs at machine, supervisor and user privilege should take an interrupt now, and which one. It receives the raw pending vector, the per-source enable vector and the delegation mask, along with the current privilege level and the two global enable bits (machine and supervisor). From these it forms the set of interrupts that may be taken at this privilege. It then reports the lowest-numbered member of that set.

Interrupts whose delegation bit is clear belong to machine level. Interrupts whose delegation bit is set are handed to supervisor level. Each group passes through its own privilege rule. The decision is registered, so the strobe and the cause appear one clock after the inputs that produced them. The cause word marks an interrupt in its most significant bit and carries the winning source number in its low bits. The register width is a parameter and may be 32 or 64 bits.

Top module: `irq_sel_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `take_irq` and `irq_cause` are cleared to zero on that edge, regardless of the other inputs.
- R2: An interrupt source is a candidate only when its bit is set in both `irq_pending` and `irq_enable`. A source that is pending but not enabled is never taken.
- R3: A candidate whose `irq_deleg` bit is 0 survives when `cur_priv` is numerically below 3, or when `cur_priv` is 3 and `m_ie` is 1.
- R4: A candidate whose `irq_deleg` bit is 1 survives when `cur_priv` is 0, or when `cur_priv` is 1 and `s_ie` is 1. For any other privilege value the candidate is dropped.
- R5: When several candidates survive, the one with the lowest bit index is reported.
- R6: When an interrupt is reported, bit XLEN-1 of `irq_cause` is 1, bits [IDX_W-1:0] hold the winning index, and all other bits are 0. IDX_W is log2(XLEN).
- R7: When no candidate survives, `take_irq` is 0 and `irq_cause` is all zeros.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A change at the inputs between edges does not alter the outputs until the next edge.
- R9: Privilege is encoded as 0 = user, 1 = supervisor, 3 = machine. The reserved value 2 is compared numerically: it is below machine and above supervisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pending | input | XLEN | Pending interrupt bits |
| irq_enable | input | XLEN | Per-source enable bits |
| irq_deleg | input | XLEN | 1 = source handed to supervisor level |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| take_irq | output | 1 | Registered strobe: an interrupt is to be taken |
| irq_cause | output | XLEN | Registered cause word with the interrupt flag in the MSB |

## Verification
On every cycle the assertions check several properties of a reported interrupt against the inputs of the cycle before:
- the cause word has a well-formed shape;
- the winner was both pending and enabled;
- no lower candidate was skipped;
- the winner's group passed its privilege rule.

They also check that the cause is all zeros when nothing is reported. The assertions cannot show that a surviving interrupt was never silently dropped, or that reset masks a live request. The one-edge latency also has to be shown by stimulus. The bench covers these by sweeping every privilege value and global-enable pair against single-bit patterns and random patterns.

// File: rtl/irq_sel_pkg.sv
// Shared types for the interrupt selector.
// Assumes a two-bit privilege field; value 2 is reserved and compared numerically.
package irq_sel_pkg;
    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUPV = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_MACH = 2'd3
    } priv_e;
endpackage

// File: rtl/irq_gate.sv
// Forms the set of interrupts allowed at the current privilege.
// Machine-owned and delegated sources are gated by separate rules.
// Assumes all vectors share the width XLEN.
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pending,
    input  logic [XLEN-1:0] enable,
    input  logic [XLEN-1:0] deleg,
    input  priv_e           priv,
    input  logic            m_ie,
    input  logic            s_ie,
    output logic [XLEN-1:0] survivors
);
    logic [XLEN-1:0] cand;
    logic            m_open;
    logic            s_open;

    // Evaluate the privilege rules and mask the two groups.
    always_comb begin
        cand   = pending & enable;
        m_open = (priv < PRIV_MACH) || ((priv == PRIV_MACH) && m_ie);
        s_open = (priv < PRIV_SUPV) || ((priv == PRIV_SUPV) && s_ie);
        survivors = (cand & ~deleg & {XLEN{m_open}})
                  | (cand &  deleg & {XLEN{s_open}});
    end
endmodule

// File: rtl/irq_lowest_pick.sv
// Finds the lowest set bit of a vector (trailing-zero count).
// Assumes IDX_W is at least log2(XLEN); the index is 0 when the vector is empty.
module irq_lowest_pick #(
    parameter int XLEN  = 64,
    parameter int IDX_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        found = |vec;
    end
endmodule

// File: rtl/irq_sel_top.sv
// Registered interrupt selection for a hart with U, S and M levels.
// It gates the pending and enabled sources by privilege and picks the lowest index.
// The strobe and cause appear one cycle after the inputs.
// Assumes XLEN is 32 or 64.
module irq_sel_top
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] irq_pending,
    input  logic [XLEN-1:0] irq_enable,
    input  logic [XLEN-1:0] irq_deleg,
    input  logic [1:0]      cur_priv,
    input  logic            m_ie,
    input  logic            s_ie,
    output logic            take_irq,
    output logic [XLEN-1:0] irq_cause
);
    localparam int IDX_W = $clog2(XLEN);
    localparam int PAD_W = XLEN - 1 - IDX_W;

    logic [XLEN-1:0]  survivors;
    logic             hit;
    logic [IDX_W-1:0] win_idx;
    logic [XLEN-1:0]  cause_next;

    irq_gate #(.XLEN(XLEN)) u_gate (
        .pending   (irq_pending),
        .enable    (irq_enable),
        .deleg     (irq_deleg),
        .priv      (priv_e'(cur_priv)),
        .m_ie      (m_ie),
        .s_ie      (s_ie),
        .survivors (survivors)
    );

    irq_lowest_pick #(.XLEN(XLEN), .IDX_W(IDX_W)) u_pick (
        .vec   (survivors),
        .found (hit),
        .idx   (win_idx)
    );

    // Build the cause word: interrupt flag in the MSB, index in the low bits.
    always_comb begin
        cause_next = hit ? {1'b1, {PAD_W{1'b0}}, win_idx} : '0;
    end

    // Register the decision; clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_irq  <= 1'b0;
            irq_cause <= '0;
        end else begin
            take_irq  <= hit;
            irq_cause <= cause_next;
        end
    end
endmodule

// File: rtl/irq_sel_chk.sv
// Checker for irq_sel_top. It relates each registered output to the inputs of the previous cycle.
// Attached to every instance by the bind statement below.
module irq_sel_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] irq_pending,
    input logic [XLEN-1:0] irq_enable,
    input logic [XLEN-1:0] irq_deleg,
    input logic [1:0]      cur_priv,
    input logic            m_ie,
    input logic            s_ie,
    input logic            take_irq,
    input logic [XLEN-1:0] irq_cause
);
    localparam int IDX_W = $clog2(XLEN);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [IDX_W-1:0] idx;
    logic [XLEN-1:0]  below_mask;
    logic [XLEN-1:0]  hi_bits;

    // Decode the reported index and the bits beneath it.
    always_comb begin
        idx        = irq_cause[IDX_W-1:0];
        below_mask = (ONE << idx) - ONE;
        hi_bits    = irq_cause & ~(XLEN'(1) << (XLEN - 1)) & ~((ONE << IDX_W) - ONE);
    end

    p_cause_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (irq_cause[XLEN-1] && (hi_bits == '0)));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> (irq_cause == '0));

    p_candidate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (((($past(irq_pending) & $past(irq_enable)) >> idx) & ONE) == ONE));

    p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (($past(irq_pending) & $past(irq_enable) & below_mask
                       & ~($past(irq_deleg) & {XLEN{!(($past(cur_priv) == 2'd0)
                           || ($past(cur_priv) == 2'd1 && $past(s_ie)))}})
                       & ~(~$past(irq_deleg) & {XLEN{!(($past(cur_priv) != 2'd3)
                           || $past(m_ie))}})) == '0));

    p_mach_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && ((($past(irq_deleg) >> idx) & ONE) == '0))
            |-> (($past(cur_priv) != 2'd3) || $past(m_ie)));

    p_supv_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && ((($past(irq_deleg) >> idx) & ONE) == ONE))
            |-> (($past(cur_priv) == 2'd0) || ($past(cur_priv) == 2'd1 && $past(s_ie))));
endmodule

bind irq_sel_top irq_sel_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .irq_deleg   (irq_deleg),
    .cur_priv    (cur_priv),
    .m_ie        (m_ie),
    .s_ie        (s_ie),
    .take_irq    (take_irq),
    .irq_cause   (irq_cause)
);

// File: tb/sim_irq_sel_top.sv
// Self-checking bench for irq_sel_top. It sweeps privilege, the global enables and the interrupt patterns.
module sim_irq_sel_top;
    localparam int XLEN  = 64;
    localparam int IDX_W = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] pend = '0, en = '0, dg = '0;
    logic [1:0]      priv = 2'd0;
    logic            mie = 1'b0, sie = 1'b0;
    logic            take_irq;
    logic [XLEN-1:0] irq_cause;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_sel_top #(.XLEN(XLEN)) u0 (
        .clk (clk), .rst_n (rst_n),
        .irq_pending (pend), .irq_enable (en), .irq_deleg (dg),
        .cur_priv (priv), .m_ie (mie), .s_ie (sie),
        .take_irq (take_irq), .irq_cause (irq_cause)
    );

    // Reference model written from the requirements.
    function automatic logic [XLEN:0] model(input logic [XLEN-1:0] p, input logic [XLEN-1:0] e,
                                            input logic [XLEN-1:0] d, input logic [1:0] pv,
                                            input logic mi, input logic si);
        logic [XLEN-1:0] c, s, cause;
        logic m_ok, s_ok, t;
        c     = p & e;
        m_ok  = (pv < 2'd3) || (pv == 2'd3 && mi);
        s_ok  = (pv == 2'd0) || (pv == 2'd1 && si);
        s     = (c & ~d & {XLEN{m_ok}}) | (c & d & {XLEN{s_ok}});
        t     = 1'b0;
        cause = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (s[i] && !t) begin
                t = 1'b1;
                cause = (XLEN'(1) << (XLEN - 1)) | XLEN'(i);
            end
        end
        return {t, cause};
    endfunction

    task automatic check(input string req, input logic et, input logic [XLEN-1:0] ec);
        n_chk++;
        if (take_irq !== et || irq_cause !== ec) begin
            n_bad++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     req, take_irq, irq_cause, et, ec);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, then compare at the next falling edge.
    task automatic apply(input string req, input logic [XLEN-1:0] p, input logic [XLEN-1:0] e,
                         input logic [XLEN-1:0] d, input logic [1:0] pv,
                         input logic mi, input logic si);
        logic [XLEN:0] r;
        pend = p; en = e; dg = d; priv = pv; mie = mi; sie = si;
        r = model(p, e, d, pv, mi, si);
        @(posedge clk);
        @(negedge clk);
        check(req, r[XLEN], r[XLEN-1:0]);
    endtask

    function automatic logic [XLEN-1:0] rnd();
        return {$urandom, $urandom};
    endfunction

    initial begin
        // R1: inputs that would fire are held off while reset is low.
        pend = '1; en = '1; dg = '0; priv = 2'd0; mie = 1'b1; sie = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 1'b0, '0);
        rst_n = 1'b1;

        for (int pv = 0; pv < 4; pv++) begin
            for (int g = 0; g < 4; g++) begin
                // R3 R4 R6 R9: each source alone, machine-owned and then delegated.
                for (int b = 0; b < XLEN; b++) begin
                    apply("R3 R6 R9 single machine", XLEN'(1) << b, '1, '0, 2'(pv), g[0], g[1]);
                    apply("R4 R6 R9 single delegated", XLEN'(1) << b, '1, '1, 2'(pv), g[0], g[1]);
                end
                // R7: nothing pending.
                apply("R7 empty", '0, '1, rnd(), 2'(pv), g[0], g[1]);
                // R2: all pending, none enabled.
                apply("R2 pending without enable", '1, '0, rnd(), 2'(pv), g[0], g[1]);
                // R5: random mixtures.
                for (int k = 0; k < 40; k++)
                    apply("R5 R3 R4 random", rnd(), rnd(), rnd(), 2'(pv), g[0], g[1]);
            end
        end

        // R5: two sources in different groups; the lower index wins.
        apply("R5 lower wins", (XLEN'(1) << 9) | (XLEN'(1) << 3), '1, XLEN'(1) << 9, 2'd0, 1'b0, 1'b0);
        // R8: outputs hold between edges after the inputs change.
        apply("R8 set", XLEN'(1) << 5, '1, '0, 2'd0, 1'b0, 1'b0);
        pend = '0;
        #1;
        check("R8 hold", 1'b1, (XLEN'(1) << (XLEN - 1)) | XLEN'(5));
        @(posedge clk);
        @(negedge clk);
        check("R8 update", 1'b0, '0);
        // R1: reset clears a live output.
        apply("R1 before", XLEN'(1) << 2, '1, '0, 2'd0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reassert", 1'b0, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule